// File: doc/BRIEF.md
# DMA Channel Request/Acknowledge Front End

This block is the external handshake side of a single DMA channel. It watches a DREQ pin from an outside device and turns it into a transfer request for a bus sequencer. Once the bus is granted, it drives a DACK pin in the bus phase that the configuration selects. It also decides whether a grant is used for a single unit (cycle-steal) or for back-to-back units (burst). A transfer counter tracks the remaining units. Reaching zero ends the job: a done flag is raised and the channel disables itself.

Software writes a six-bit mode word and a count through a simple write port. DREQ can be sensed either as a low level or as a falling edge. DACK can be active high or active low. In dual-address transfers DACK marks either the read phase or the write phase. In single-address transfers DACK covers both phases. A standby input clears all mode bits.

Top module: `dma_hs_chan`

## Requirements
- R1: After reset, dack_o is 0, bus_req_o is 0, ctrl_o is 0, count_o is 0 and done_o is 0.
- R2: The mode word is bit0 enable, bit1 dual-address, bit2 ack-on-write, bit3 ack-active-low, bit4 edge sensing, bit5 burst. With bit4 = 0, a DREQ low level that has passed the two-stage synchronizer raises bus_req_o, provided the channel is enabled and the count is non-zero. A high DREQ raises no request. Without a count write, the count never increases.
- R3: With bit4 = 1, a synchronized falling edge of DREQ sets a pending flag, and that flag raises the request. The flag clears when the grant starts a transfer. A DREQ held low without a new edge starts no further transfer.
- R4: With bit3 = 1, DACK is active low. Its inactive level tracks bit3 from the clock after the write.
- R5: In dual-address mode (bit1 = 1), DACK is active only during the read strobe when bit2 = 0, and only during the write strobe when bit2 = 1.
- R6: In single-address mode (bit1 = 0), DACK is active during both strobes whatever the value of bit2.
- R7: In cycle-steal mode (bit5 = 0), bus_req_o drops in the cycle after each unit ends. A unit ends on a write strobe.
- R8: In burst mode (bit5 = 1), bus_req_o stays high across units. In level sensing, a synchronized high DREQ seen at a unit boundary ends the burst after that unit.
- R9: When the last unit ends, the count reaches 0, done_o is set, bit0 is cleared and the bus is released. Writing a mode word with bit0 = 1 clears done_o.
- R10: A standby pulse clears all six mode bits on the next clock.
- R11: While the channel is idle or disabled, DACK stays at its inactive level. Strobes outside an owned transfer have no effect on DACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| standby_i | input | 1 | Standby entry; clears the mode bits |
| cfg_we_i | input | 1 | Mode word write strobe |
| cfg_wdata_i | input | 6 | Mode word value |
| cnt_we_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | CNT_W | Count value |
| dreq_i | input | 1 | External request pin, asynchronous |
| bus_gnt_i | input | 1 | Bus grant from the sequencer |
| rd_phase_i | input | 1 | Read phase strobe |
| wr_phase_i | input | 1 | Write phase strobe; ends a unit |
| dack_o | output | 1 | Acknowledge pin |
| bus_req_o | output | 1 | Request for, or hold of, the bus |
| ctrl_o | output | 6 | Current mode word |
| count_o | output | CNT_W | Remaining units |
| done_o | output | 1 | Terminal count reached |

## Verification
The assertions assume that the sequencer raises a strobe only as a single-cycle pulse. They also assume that a count write and a mode write never land in the same cycle as the end of a unit. The bench's sequencer model grants only while a request is pending. Inside an owned transfer it issues read and write strobes on a fixed three-cycle pattern. Stray strobes are injected only while the channel is idle. Register writes are made only between jobs or while no unit is closing.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;
  localparam int CTRL_W = 6;

  typedef struct packed {
    logic burst;      // bit5
    logic edge_mode;  // bit4
    logic ack_low;    // bit3
    logic ack_on_wr;  // bit2
    logic dual;       // bit1
    logic en;         // bit0
  } ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2
  } chan_st_t;

  // Is this bus cycle one in which the acknowledge belongs?
  function automatic logic ack_window(input ctrl_t c, input logic rd, input logic wr);
    if (c.dual) return c.ack_on_wr ? wr : rd;
    return rd | wr;
  endfunction

  // Map a logical assertion to the pin level
  function automatic logic pin_level(input logic active, input logic act_low);
    return active ^ act_low;
  endfunction

  // Count after one unit completes; never wraps below zero
  function automatic logic [31:0] count_after(input logic [31:0] cnt);
    return (cnt == 32'd0) ? 32'd0 : cnt - 32'd1;
  endfunction
endpackage

// File: rtl/dma_hs_req_sense.sv
module dma_hs_req_sense
  import dma_hs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic dreq_i,
  input  logic en_i,
  input  logic edge_mode_i,
  input  logic xfer_start_i,
  output logic lvl_req_o,
  output logic fall_o,
  output logic pend_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   pend_q;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_n_i) begin
          if (!rst_n_i) sync_q[0] <= 1'b1;
          else          sync_q[0] <= dreq_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_n_i) begin
          if (!rst_n_i) sync_q[g] <= 1'b1;
          else          sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) prev_q <= 1'b1;
    else          prev_q <= sync_q[LAST];
  end

  assign lvl_req_o = ~sync_q[LAST];
  assign fall_o    = prev_q & ~sync_q[LAST];

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)                 pend_q <= 1'b0;
    else if (!en_i || !edge_mode_i) pend_q <= 1'b0;
    else if (fall_o)              pend_q <= 1'b1;
    else if (xfer_start_i)        pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/dma_hs_regs.sv
module dma_hs_regs
  import dma_hs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             standby_i,
  input  logic             cfg_we_i,
  input  logic [CTRL_W-1:0] cfg_wdata_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             unit_end_i,
  input  logic             last_unit_i,
  output ctrl_t            ctrl_o,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  ctrl_t            wr_word;
  logic [31:0]      cnt_wide;
  logic [31:0]      cnt_dec;

  assign wr_word  = ctrl_t'(cfg_wdata_i);
  assign cnt_wide = 32'(cnt_q);
  assign cnt_dec  = count_after(cnt_wide);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)         ctrl_q <= '0;
    else if (standby_i)   ctrl_q <= '0;
    else if (cfg_we_i)    ctrl_q <= wr_word;
    else if (last_unit_i) ctrl_q.en <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)                   done_q <= 1'b0;
    else if (cfg_we_i && wr_word.en) done_q <= 1'b0;
    else if (last_unit_i)           done_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)        cnt_q <= '0;
    else if (cnt_we_i)   cnt_q <= cnt_wdata_i;
    else if (unit_end_i) cnt_q <= cnt_dec[CNT_W-1:0];
  end

  assign ctrl_o  = ctrl_q;
  assign count_o = cnt_q;
  assign done_o  = done_q;
endmodule

// File: rtl/dma_hs_seq.sv
module dma_hs_seq
  import dma_hs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  ctrl_t            ctrl_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             lvl_req_i,
  input  logic             pend_i,
  input  logic             bus_gnt_i,
  input  logic             wr_phase_i,
  output chan_st_t         st_o,
  output logic             xfer_start_o,
  output logic             unit_end_o,
  output logic             last_unit_o
);
  chan_st_t st_q, st_d;
  logic     req_now;
  logic     cnt_nz;

  assign req_now      = ctrl_i.edge_mode ? pend_i : lvl_req_i;
  assign cnt_nz       = (count_i != '0);
  assign xfer_start_o = (st_q == ST_REQ) && ctrl_i.en && bus_gnt_i;
  assign unit_end_o   = (st_q == ST_XFER) && ctrl_i.en && wr_phase_i;
  assign last_unit_o  = unit_end_o && (count_i <= CNT_W'(1));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (ctrl_i.en && cnt_nz && req_now) st_d = ST_REQ;
      ST_REQ: begin
        if (!ctrl_i.en)     st_d = ST_IDLE;
        else if (bus_gnt_i) st_d = ST_XFER;
      end
      ST_XFER: begin
        if (!ctrl_i.en) st_d = ST_IDLE;
        else if (unit_end_o) begin
          if (last_unit_o)                            st_d = ST_IDLE;
          else if (!ctrl_i.burst)                     st_d = ST_IDLE;
          else if (!ctrl_i.edge_mode && !lvl_req_i)   st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) st_q <= ST_IDLE;
    else          st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/dma_hs_ack.sv
module dma_hs_ack
  import dma_hs_pkg::*;
(
  input  ctrl_t    ctrl_i,
  input  chan_st_t st_i,
  input  logic     rd_phase_i,
  input  logic     wr_phase_i,
  output logic     ack_active_o,
  output logic     dack_o
);
  assign ack_active_o = (st_i == ST_XFER) && ctrl_i.en &&
                        ack_window(ctrl_i, rd_phase_i, wr_phase_i);
  assign dack_o = pin_level(ack_active_o, ctrl_i.ack_low);
endmodule

// File: rtl/dma_hs_chan.sv
module dma_hs_chan
  import dma_hs_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             standby_i,
  input  logic             cfg_we_i,
  input  logic [5:0]       cfg_wdata_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             dreq_i,
  input  logic             bus_gnt_i,
  input  logic             rd_phase_i,
  input  logic             wr_phase_i,
  output logic             dack_o,
  output logic             bus_req_o,
  output logic [5:0]       ctrl_o,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o
);
  ctrl_t    ctrl;
  chan_st_t st;
  logic     lvl_req, fall, pend;
  logic     xfer_start, unit_end, last_unit, ack_active;

  dma_hs_req_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .dreq_i(dreq_i),
    .en_i(ctrl.en), .edge_mode_i(ctrl.edge_mode), .xfer_start_i(xfer_start),
    .lvl_req_o(lvl_req), .fall_o(fall), .pend_o(pend)
  );

  dma_hs_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .standby_i(standby_i),
    .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .cnt_we_i(cnt_we_i), .cnt_wdata_i(cnt_wdata_i),
    .unit_end_i(unit_end), .last_unit_i(last_unit),
    .ctrl_o(ctrl), .count_o(count_o), .done_o(done_o)
  );

  dma_hs_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .ctrl_i(ctrl), .count_i(count_o),
    .lvl_req_i(lvl_req), .pend_i(pend), .bus_gnt_i(bus_gnt_i),
    .wr_phase_i(wr_phase_i), .st_o(st), .xfer_start_o(xfer_start),
    .unit_end_o(unit_end), .last_unit_o(last_unit)
  );

  dma_hs_ack u_ack (
    .ctrl_i(ctrl), .st_i(st), .rd_phase_i(rd_phase_i), .wr_phase_i(wr_phase_i),
    .ack_active_o(ack_active), .dack_o(dack_o)
  );

  assign bus_req_o = (st != ST_IDLE);
  assign ctrl_o    = ctrl;
endmodule

// File: rtl/dma_hs_chan_chk.sv
module dma_hs_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_n_i,
  input logic             standby_i,
  input logic             cnt_we_i,
  input logic             rd_phase_i,
  input logic             wr_phase_i,
  input logic             dack_o,
  input logic             bus_req_o,
  input logic [5:0]       ctrl_o,
  input logic [CNT_W-1:0] count_o,
  input logic             done_o,
  input logic             unit_end,
  input logic             xfer_start,
  input logic             fall,
  input logic             pend
);
  a_r11_idle_dack_inactive: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !bus_req_o |-> (dack_o == ctrl_o[3]));

  a_r5_dack_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (dack_o != ctrl_o[3]) |-> (rd_phase_i || wr_phase_i));

  a_r7_steal_releases: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (unit_end && !ctrl_o[5]) |=> !bus_req_o);

  a_r9_done_disables: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(done_o) |-> !ctrl_o[0]);

  a_r3_pend_clears: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (xfer_start && !fall) |=> !pend);

  a_r2_count_no_rise: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !cnt_we_i |=> (count_o <= $past(count_o)));

  a_r10_standby_clears: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    standby_i |=> (ctrl_o == 6'd0));
endmodule

bind dma_hs_chan dma_hs_chan_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i(clk_i), .rst_n_i(rst_n_i), .standby_i(standby_i), .cnt_we_i(cnt_we_i),
  .rd_phase_i(rd_phase_i), .wr_phase_i(wr_phase_i), .dack_o(dack_o),
  .bus_req_o(bus_req_o), .ctrl_o(ctrl_o), .count_o(count_o), .done_o(done_o),
  .unit_end(unit_end), .xfer_start(xfer_start), .fall(fall), .pend(pend)
);

// File: tb/dma_hs_chan_tb.sv
module dma_hs_chan_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic standby = 0, cfg_we = 0, cnt_we = 0, dreq = 1, gnt = 0, rd = 0, wr = 0;
  logic [5:0] cfg_wdata = '0;
  logic [CNT_W-1:0] cnt_wdata = '0;
  logic dack, bus_req, done;
  logic [5:0] ctrl;
  logic [CNT_W-1:0] count;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";
  bit stray = 0;
  bit finished = 0;

  // behavioural reference state
  int m_st = 0;      // 0 idle, 1 request, 2 owning bus
  int m_ph = 0;
  int m_cnt = 0;
  int m_ctrl = 0;
  int m_done = 0;
  int m_pend = 0;
  int m_prev = 1;
  bit sq[$];         // synchronizer history, newest at front

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_hs_chan #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .standby_i(standby), .cfg_we_i(cfg_we),
    .cfg_wdata_i(cfg_wdata), .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wdata),
    .dreq_i(dreq), .bus_gnt_i(gnt), .rd_phase_i(rd), .wr_phase_i(wr),
    .dack_o(dack), .bus_req_o(bus_req), .ctrl_o(ctrl), .count_o(count), .done_o(done)
  );

  function automatic bit mb(int b);
    return ((m_ctrl >> b) & 1) != 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_dack();
    bit on = 0;
    if (m_st == 2 && mb(0)) begin
      if (mb(1)) on = mb(2) ? wr : rd;
      else       on = rd || wr;
    end
    return (on != mb(3)) ? 1 : 0;
  endfunction

  task automatic compare_all();
    chk({cur_req, " dack"},    int'(dack),    exp_dack());
    chk({cur_req, " bus_req"}, int'(bus_req), (m_st != 0) ? 1 : 0);
    chk({cur_req, " count"},   int'(count),   m_cnt);
    chk({cur_req, " ctrl"},    int'(ctrl),    m_ctrl);
    chk({cur_req, " done"},    int'(done),    m_done);
  endtask

  task automatic model_step();
    bit en = mb(0), edg = mb(4), bst = mb(5);
    bit s2 = sq[1];
    bit lvl = !s2;
    bit fall = (m_prev == 1) && !s2;
    bit reqnow = edg ? (m_pend != 0) : lvl;
    bit start = (m_st == 1) && en && gnt;
    bit ue = (m_st == 2) && en && wr;
    bit last = ue && (m_cnt <= 1);
    int nst = m_st;
    if (m_st == 0) begin
      if (en && m_cnt != 0 && reqnow) nst = 1;
    end else if (m_st == 1) begin
      if (!en) nst = 0; else if (gnt) nst = 2;
    end else begin
      if (!en) nst = 0;
      else if (ue && (last || !bst || (!edg && !lvl))) nst = 0;
    end
    if (!en || !edg) m_pend = 0;
    else if (fall)   m_pend = 1;
    else if (start)  m_pend = 0;
    if (cfg_we && cfg_wdata[0]) m_done = 0;
    else if (last)              m_done = 1;
    if (standby)     m_ctrl = 0;
    else if (cfg_we) m_ctrl = int'(cfg_wdata);
    else if (last)   m_ctrl = m_ctrl & ~1;
    if (cnt_we)                m_cnt = int'(cnt_wdata);
    else if (ue && m_cnt != 0) m_cnt = m_cnt - 1;
    m_ph = (m_st == 2 && nst == 2) ? (m_ph + 1) % 3 : 0;
    m_st = nst;
    m_prev = s2;
    sq.push_front(dreq);
    void'(sq.pop_back());
  endtask

  task automatic tick();
    gnt = (m_st == 1);
    rd  = (m_st == 2 && m_ph == 0) || (stray && m_st == 0);
    wr  = (m_st == 2 && m_ph == 1) || (stray && m_st == 0);
    #1;
    compare_all();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wcfg(logic [5:0] v);
    cfg_we = 1; cfg_wdata = v; tick(); cfg_we = 0;
  endtask

  task automatic wcnt(int v);
    cnt_we = 1; cnt_wdata = CNT_W'(v); tick(); cnt_we = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG && !finished) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
        summary();
      end
    end
  end

  initial begin
    sq.push_back(1); sq.push_back(1);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset values
    cur_req = "R1";
    #1;
    chk("R1 dack after reset", int'(dack), 0);
    chk("R1 bus_req after reset", int'(bus_req), 0);
    chk("R1 ctrl after reset", int'(ctrl), 0);
    chk("R1 count after reset", int'(count), 0);
    chk("R1 done after reset", int'(done), 0);
    @(negedge clk);

    // R2 level sensing, cycle-steal, dual, read phase ack, active high
    cur_req = "R2";
    wcnt(3);
    wcfg(6'b000011);
    run(6);
    chk("R2 no request while DREQ high", int'(bus_req), 0);
    cur_req = "R7";
    dreq = 0;
    run(40);
    cur_req = "R9";
    chk("R9 count spent", int'(count), 0);
    chk("R9 done set", int'(done), 1);
    chk("R9 enable cleared", int'(ctrl[0]), 0);
    chk("R9 bus released", int'(bus_req), 0);

    // R4 / R5: active low, write phase ack, burst
    cur_req = "R5";
    wcnt(4);
    wcfg(6'b101111);
    chk("R9 done cleared by enable write", int'(done), 0);
    cur_req = "R4";
    run(30);
    chk("R4 idle level is high when active low", int'(dack), 1);

    // R8 level burst stopped by DREQ going high
    cur_req = "R8";
    wcnt(10);
    wcfg(6'b100011);
    run(8);
    dreq = 1;
    run(14);
    chk("R8 burst ended by inactive DREQ", int'(bus_req), 0);
    chk("R8 count left over", (count != 0) ? 1 : 0, 1);
    wcfg(6'b000000);

    // R3 edge burst: one edge runs the whole count
    cur_req = "R3";
    run(4);
    wcnt(3);
    wcfg(6'b110011);
    run(3);
    dreq = 0;
    run(25);
    chk("R3 edge burst spent count", int'(count), 0);
    // R3 edge cycle-steal: a held low gives only one unit
    dreq = 1;
    run(4);
    wcnt(3);
    wcfg(6'b010011);
    run(3);
    dreq = 0;
    run(20);
    chk("R3 single unit per edge", int'(count), 2);
    dreq = 1;
    run(3);
    dreq = 0;
    run(20);
    chk("R3 second edge second unit", int'(count), 1);

    // R6 single-address: ack on both strobes
    cur_req = "R6";
    wcfg(6'b000000);
    dreq = 1;
    run(3);
    wcnt(2);
    wcfg(6'b000101);
    dreq = 0;
    run(20);
    chk("R6 single-address job complete", int'(done), 1);

    // R11 stray strobes while disabled, active-low polarity
    cur_req = "R11";
    dreq = 1;
    wcfg(6'b001000);
    chk("R4 polarity applied next clock", int'(dack), 1);
    stray = 1;
    run(6);
    chk("R11 stray strobe leaves DACK inactive", int'(dack), 1);
    stray = 0;

    // R10 standby clears mode bits
    cur_req = "R10";
    wcfg(6'b111110);
    run(2);
    standby = 1;
    tick();
    standby = 0;
    run(2);
    chk("R10 mode bits cleared by standby", int'(ctrl), 0);

    finished = 1;
    summary();
  end
endmodule